// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block gathers single-cycle event pulses from eleven second-level interrupt groups and reduces them to one level-sensitive interrupt line. Each group holds four 32-bit words: a read-only status word, a mask, an identity word and an enable. An event pulse on an unmasked bit sets that bit in the group's identity word. Software clears identity bits by writing ones to them. A group, or one 16-bit half of a group, counts as pending when any identity bit it owns is also enabled.

A top-level master word holds one summary bit for each routed group or half-group, and a global enable in bit 31. A fixed routing table picks which summary bit each group drives. Some groups split into low and high halves that feed two separate summary bits. The summary bits follow the group state; they are not latched. The interrupt line is high when the global enable is set and at least one summary bit is set.

Software reaches every word through a simple write-strobe bus with a combinational read port. Group g sits at byte base 16*g. Within a group, status, mask, identity and enable sit at offsets 0x0, 0x4, 0x8 and 0xC. The master word sits at byte address 0xB0.

Top module: `irq_agg_top`

## Requirements
- R1: Mask and enable words read back the value last written. The status word reads the group's slice of `raw_i` and ignores writes. Any unmapped address reads zero, including 0xB4 to 0xBC and all addresses at or above 0xC0.
- R2: An event pulse sets identity bit b of a group only when mask bit b is 0. An event that arrives while the bit is masked is dropped, and clearing the mask afterwards does not set the bit.
- R3: A write to the identity word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event and an identity clear hit the same bit in the same cycle, the bit ends set.
- R5: Summary routing, with bit positions as the master word shows them:
  - group 0: bits [15:0] drive summary bit 0 and bits [31:16] drive bit 1.
  - group 1: the low half drives bit 2 and the high half drives bit 3.
  - group 2: the low half drives bit 4. Its high half drives nothing.
  - group 3: the low half drives bit 6. Its high half drives nothing.
  - groups 4, 5 and 6: all 32 bits drive bits 16, 17 and 18.
  - group 7 drives bit 20, group 8 drives bit 22, group 9 drives bit 30 and group 10 drives bit 23.
  - All other summary positions read 0.
- R6: A summary bit drops, and the interrupt line with it, once the pending bits that drive it are cleared or disabled.
- R7: A write to the master word changes only bit 31, the global enable. All other written bits are ignored.
- R8: `irq_o` is 1 only while the global enable is 1 and some summary bit is 1. While the global enable is 0, the summary bits hold their last value and are not recomputed.
- R9: After reset, every stored word, the global enable and `irq_o` are 0.
- R10: A summary bit and `irq_o` change on the clock edge after the identity or enable change that causes them. They are therefore two edges behind the event pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data at bus_addr_i |
| raw_i | input | 11x32 | Raw status word of each group |
| evt_i | input | 11x32 | Single-cycle event pulses of each group |
| irq_o | output | 1 | Level interrupt output |

## Verification
An event pulse and a write-one-to-clear to the same identity bit can land in the same cycle. The bench provokes this by driving the pulse and the bus write on the same clock edge, for both a bit that is already set and one that is not. It then judges the result by reading the identity word back and by checking that the interrupt line still follows the surviving bit. A second sweep drives a single enabled event into every bit of every group. For each one it checks the identity word, the summary position given by the routing rules, the two-edge latency, and the drop after the clear.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DW     = 32;
  localparam int NGRP   = 11;
  localparam int NSUM   = DW - 1;
  localparam int EN_BIT = DW - 1;
  localparam int AW     = 8;
  localparam int MST_SEL = NGRP;

  // group feeding summary bit m, -1 when unrouted
  function automatic int route_grp(int m);
    case (m)
      0, 1:    return 0;
      2, 3:    return 1;
      4:       return 2;
      6:       return 3;
      16:      return 4;
      17:      return 5;
      18:      return 6;
      20:      return 7;
      22:      return 8;
      30:      return 9;
      23:      return 10;
      default: return -1;
    endcase
  endfunction

  function automatic logic [DW-1:0] route_msk(int m);
    case (m)
      0, 2, 4, 6: return {{(DW/2){1'b0}}, {(DW/2){1'b1}}};
      1, 3:       return {{(DW/2){1'b1}}, {(DW/2){1'b0}}};
      default:    return '1;
    endcase
  endfunction
endpackage

// File: rtl/irq_grp.sv
module irq_grp
  import irq_agg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_msk_i,
  input  logic          we_ena_i,
  input  logic          we_idn_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] evt_i,
  output logic [DW-1:0] msk_o,
  output logic [DW-1:0] ena_o,
  output logic [DW-1:0] idn_o,
  output logic [DW-1:0] pend_o
);
  logic [DW-1:0] msk_q, ena_q, idn_q, clr, idn_d;

  assign clr   = we_idn_i ? wdata_i : '0;
  // new events win over a same-cycle clear
  assign idn_d = (idn_q & ~clr) | (evt_i & ~msk_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msk_q <= '0;
      ena_q <= '0;
      idn_q <= '0;
    end else begin
      if (we_msk_i) msk_q <= wdata_i;
      if (we_ena_i) ena_q <= wdata_i;
      idn_q <= idn_d;
    end
  end

  assign msk_o  = msk_q;
  assign ena_o  = ena_q;
  assign idn_o  = idn_q;
  assign pend_o = idn_q & ena_q;
endmodule

// File: rtl/irq_master.sv
module irq_master
  import irq_agg_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic                     en_wr_i,
  input  logic [NGRP-1:0][DW-1:0]  pend_i,
  output logic                     en_o,
  output logic [NSUM-1:0]          sum_o,
  output logic                     irq_o
);
  logic [NSUM-1:0] fresh, sum_q, sum_d;
  logic            en_q, irq_q;

  for (genvar m = 0; m < NSUM; m++) begin : g_route
    localparam int G = route_grp(m);
    if (G >= 0) begin : g_on
      assign fresh[m] = |(pend_i[G] & route_msk(m));
    end else begin : g_off
      assign fresh[m] = 1'b0;
    end
  end

  // recompute only while globally enabled
  assign sum_d = en_q ? fresh : sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      sum_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (we_i) en_q <= en_wr_i;
      sum_q <= sum_d;
      irq_q <= en_q & (|sum_d);
    end
  end

  assign en_o  = en_q;
  assign sum_o = sum_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bus_we_i,
  input  logic [AW-1:0]           bus_addr_i,
  input  logic [DW-1:0]           bus_wdata_i,
  output logic [DW-1:0]           bus_rdata_o,
  input  logic [NGRP-1:0][DW-1:0] raw_i,
  input  logic [NGRP-1:0][DW-1:0] evt_i,
  output logic                    irq_o
);
  localparam logic [1:0] OFS_STA = 2'd0;
  localparam logic [1:0] OFS_MSK = 2'd1;
  localparam logic [1:0] OFS_IDN = 2'd2;
  localparam logic [1:0] OFS_ENA = 2'd3;

  logic [3:0] sel;
  logic [1:0] ofs;
  logic [NGRP-1:0][DW-1:0] msk_w, ena_w, idn_w, pend_w;
  logic [NSUM-1:0] sum_w;
  logic en_w, mst_we;

  assign sel = bus_addr_i[7:4];
  assign ofs = bus_addr_i[3:2];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic hit;
    assign hit = bus_we_i && (sel == 4'(g));
    irq_grp u_grp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_msk_i (hit && ofs == OFS_MSK),
      .we_ena_i (hit && ofs == OFS_ENA),
      .we_idn_i (hit && ofs == OFS_IDN),
      .wdata_i  (bus_wdata_i),
      .evt_i    (evt_i[g]),
      .msk_o    (msk_w[g]),
      .ena_o    (ena_w[g]),
      .idn_o    (idn_w[g]),
      .pend_o   (pend_w[g])
    );
  end

  assign mst_we = bus_we_i && sel == 4'(MST_SEL) && ofs == 2'd0;

  irq_master u_mst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mst_we),
    .en_wr_i (bus_wdata_i[EN_BIT]),
    .pend_i  (pend_w),
    .en_o    (en_w),
    .sum_o   (sum_w),
    .irq_o   (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (sel < 4'(NGRP)) begin
      case (ofs)
        OFS_STA: bus_rdata_o = raw_i[sel];
        OFS_MSK: bus_rdata_o = msk_w[sel];
        OFS_IDN: bus_rdata_o = idn_w[sel];
        default: bus_rdata_o = ena_w[sel];
      endcase
    end else if (sel == 4'(MST_SEL) && ofs == 2'd0) begin
      bus_rdata_o = {en_w, sum_w};
    end
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 irq_o,
  input logic                 en_i,
  input logic [NSUM-1:0]      sum_i,
  input logic [NGRP*DW-1:0]   idn_i,
  input logic [NGRP*DW-1:0]   msk_i,
  input logic [NGRP*DW-1:0]   evt_i
);
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|sum_i)); // R8
  AST_DISABLED_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_o); // R8
  AST_DISABLED_SUM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sum_i)); // R8
  AST_MASKED_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((idn_i & ~$past(idn_i)) & ($past(msk_i) | ~$past(evt_i))) == '0); // R2
  AST_UNROUTED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {sum_i[29:24], sum_i[21], sum_i[19], sum_i[15:7], sum_i[5]} == '0); // R5
endmodule

bind irq_agg_top irq_agg_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .irq_o  (irq_o),
  .en_i   (en_w),
  .sum_i  (sum_w),
  .idn_i  (idn_w),
  .msk_i  (msk_w),
  .evt_i  (evt_i)
);

// File: tb/sim_irq_agg_top.sv
`timescale 1ns/1ps
module sim_irq_agg_top;
  import irq_agg_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NGRP-1:0][31:0] raw = '0, evt = '0;
  logic irq;
  int nvec = 0, nbad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_agg_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .raw_i(raw), .evt_i(evt), .irq_o(irq)
  );

  localparam logic [7:0] MST = 8'hB0;
  function automatic logic [7:0] ga(int g, int o); return 8'(g*16 + o*4); endfunction

  // independent model of the routing rules
  function automatic int exp_pos(int g, int b);
    case (g)
      0: return b < 16 ? 0 : 1;
      1: return b < 16 ? 2 : 3;
      2: return b < 16 ? 4 : -1;
      3: return b < 16 ? 6 : -1;
      4: return 16; 5: return 17; 6: return 18;
      7: return 20; 8: return 22; 9: return 30;
      default: return 23;
    endcase
  endfunction

  task automatic tick(); @(posedge clk); @(negedge clk); endtask
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask
  task automatic wr(logic [7:0] a, logic [31:0] d);
    we = 1; addr = a; wdata = d; tick(); we = 0;
  endtask
  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask
  task automatic pulse(int g, int b);
    evt[g][b] = 1'b1; tick(); evt = '0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R9 reset state
    for (int g = 0; g < NGRP; g++)
      for (int o = 1; o < 4; o++) begin rd(ga(g, o), v); chk("R9", v, 0); end
    rd(MST, v); chk("R9", v, 0); chk("R9 irq", {31'd0, irq}, 0);
    rst_n = 1; tick();

    // R1 readback, status mirror, unmapped
    wr(ga(5, 1), 32'hA5A5_0F0F); rd(ga(5, 1), v); chk("R1 mask", v, 32'hA5A5_0F0F);
    wr(ga(9, 3), 32'h1234_5678); rd(ga(9, 3), v); chk("R1 enable", v, 32'h1234_5678);
    raw[7] = 32'hDEAD_BEEF; wr(ga(7, 0), 32'h0); rd(ga(7, 0), v); chk("R1 status", v, 32'hDEAD_BEEF);
    rd(8'hB4, v); chk("R1 unmapped", v, 0);
    rd(8'hC8, v); chk("R1 unmapped", v, 0);
    wr(ga(5, 1), 0); wr(ga(9, 3), 0);

    // R7 master write only bit 31
    wr(MST, 32'h7FFF_FFFF); rd(MST, v); chk("R7", v, 0);
    wr(MST, 32'hFFFF_FFFF); tick(); rd(MST, v); chk("R7", v, 32'h8000_0000);

    // R2 masked event dropped
    wr(ga(0, 1), 32'h1); pulse(0, 0); rd(ga(0, 2), v); chk("R2 masked", v, 0);
    wr(ga(0, 1), 32'h0); tick(); rd(ga(0, 2), v); chk("R2 no replay", v, 0);

    // R3 write-one-to-clear
    for (int b = 0; b < 4; b++) pulse(2, b);
    rd(ga(2, 2), v); chk("R3 set", v, 32'hF);
    wr(ga(2, 2), 32'h5); rd(ga(2, 2), v); chk("R3 clr", v, 32'hA);
    wr(ga(2, 2), 32'hF); rd(ga(2, 2), v); chk("R3 clr all", v, 0);

    // R4 event and clear in same cycle
    wr(ga(1, 3), 32'h0001_0000);
    pulse(1, 16);
    evt[1][16] = 1'b1; we = 1; addr = ga(1, 2); wdata = 32'h0001_0000; tick(); we = 0; evt = '0;
    rd(ga(1, 2), v); chk("R4 set bit", v, 32'h0001_0000);
    evt[1][3] = 1'b1; we = 1; addr = ga(1, 2); wdata = 32'h8; tick(); we = 0; evt = '0;
    rd(ga(1, 2), v); chk("R4 clear bit", v, 32'h0001_0008);
    tick(); chk("R4 irq", {31'd0, irq}, 1);
    rd(MST, v); chk("R4 summary", v, 32'h8000_0008);
    wr(ga(1, 2), '1); wr(ga(1, 3), 0); tick();

    // R8 disabled: no irq, summary held
    wr(MST, 0); wr(ga(0, 3), 32'h1); pulse(0, 0); tick();
    chk("R8 irq off", {31'd0, irq}, 0);
    rd(MST, v); chk("R8 held", v, 0);
    wr(MST, 32'h8000_0000); tick();
    chk("R8 irq on", {31'd0, irq}, 1);
    rd(MST, v); chk("R8 summary", v, 32'h8000_0001);
    wr(ga(0, 3), 0); tick();
    chk("R6 disable drops", {31'd0, irq}, 0);
    wr(ga(0, 2), '1); tick();

    // sweep: every bit of every group, R5 R6 R10
    for (int g = 0; g < NGRP; g++) begin
      for (int b = 0; b < 32; b++) begin
        int p;
        logic [31:0] em;
        p = exp_pos(g, b);
        em = 32'h8000_0000 | ((p >= 0) ? (32'h1 << p) : 32'h0);
        wr(ga(g, 3), 32'h1 << b);
        pulse(g, b);
        rd(ga(g, 2), v); chk("R2 latch", v, 32'h1 << b);
        chk("R10 latency", {31'd0, irq}, 0);
        tick();
        rd(MST, v); chk("R5 route", v, em);
        chk("R5 irq", {31'd0, irq}, (p >= 0) ? 1 : 0);
        wr(ga(g, 2), 32'h1 << b); tick();
        rd(MST, v); chk("R6 clear", v, 32'h8000_0000);
        chk("R6 irq", {31'd0, irq}, 0);
      end
      wr(ga(g, 3), 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule